// File: doc/BRIEF.md
# Boot Image Preloader with Core Reset Gate

This block runs once after every power-on reset. It reads a small non-volatile boot image, byte by byte, from a synchronous ROM. It packs consecutive bytes into instruction words and writes them into the bottom of the processor's instruction RAM, starting at word 0. The processor core is held in reset during the whole transfer. Only after the last word has been stored does the block release the core, so the first instruction the core fetches always comes from a complete boot image.

Once the preload has finished, the block stays finished until the next power-on reset. A separate warm reset input can put the core back into reset at any time afterwards. A warm reset does not start a second copy, so any code the application has loaded above the boot area, or patched into it, survives a warm restart. The block has no path that writes the ROM.

Top module: `boot_preload`

## Requirements
- R1: While `rst_n` is low, `core_rst_n`, `boot_done`, `ram_we` and `rom_rd_en` are all 0.
- R2: After `rst_n` rises, the block issues exactly 128 ROM reads, one per cycle on consecutive cycles, at byte addresses 0, 1, ..., 127 in ascending order. It expects the ROM data one cycle after the read.
- R3: RAM word n is written with ROM byte 2n in bits 7:0 and ROM byte 2n+1 in bits 15:8.
- R4: Exactly 64 RAM writes occur, at word addresses 0 to 63 in ascending order. No RAM word at address 64 or above is written.
- R5: `boot_done` and `core_rst_n` both rise on the 131st rising clock edge after `rst_n` goes high, which is the cycle after word 63 is written. Both are 0 before that edge.
- R6: Once `boot_done` is 1, it stays 1 and no further ROM reads or RAM writes occur until the next power-on reset.
- R7: After the preload, `warm_rst_n` low sampled at an edge drives `core_rst_n` low from that edge on. `core_rst_n` returns high on the edge that samples `warm_rst_n` high again. `boot_done` stays 1 and no copy is repeated.
- R8: A warm reset pulse during the copy changes neither the read and write sequence nor the release timing of R5.
- R9: A new power-on reset repeats the whole copy, overwriting the words loaded by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| warm_rst_n | input | 1 | Warm reset request for the core, active low |
| rom_rd_en | output | 1 | ROM read strobe |
| rom_addr | output | 7 | ROM byte address |
| rom_data | input | 8 | ROM read data, valid one cycle after the read |
| ram_we | output | 1 | Instruction RAM write enable |
| ram_addr | output | 9 | Instruction RAM word address |
| ram_wdata | output | 16 | Instruction RAM write data |
| core_rst_n | output | 1 | Reset to the processor core, active low |
| boot_done | output | 1 | Preload complete |

## Verification
The bench builds the block with its default parameters: a 128-byte image, 16-bit words formed from two byte lanes, and a 512-word instruction RAM. Because the RAM is deeper than the 64-word image, a write that strays above word 63 leaves a visible mark in the bench's RAM model. The two-lane packing lets a swapped or misaligned byte show up in every word. Each power-on uses a different ROM pattern, so a repeated copy must visibly replace the words left by the previous one.

// File: rtl/boot_preload_pkg.sv
// Shared types for the boot image preloader.
package boot_preload_pkg;

    // Sequencer states: waiting after power-on, transferring, finished.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COPY = 2'd1,
        ST_DONE = 2'd2
    } boot_state_e;

endpackage

// File: rtl/boot_seq_fsm.sv
// Preload sequencer.
// Issues one ROM byte read per cycle, from address 0 to ROM_BYTES-1,
// and enters DONE when the packer reports the final word write.
// Assumes: ROM_BYTES is a power of two; the power-on reset is synchronous and active low.
module boot_seq_fsm
    import boot_preload_pkg::*;
#(
    parameter int ROM_BYTES = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         last_wr_i,
    output logic                         rd_en_o,
    output logic [$clog2(ROM_BYTES)-1:0] rd_addr_o,
    output logic                         done_next_o
);
    localparam int BA = $clog2(ROM_BYTES);
    localparam int CW = BA + 1;

    boot_state_e   state_q, state_nx;
    logic [CW-1:0] cnt_q;

    // Reads are issued while copying and until every byte has been requested.
    always_comb begin
        rd_en_o   = (state_q == ST_COPY) && (cnt_q < CW'(ROM_BYTES));
        rd_addr_o = cnt_q[BA-1:0];
    end

    // Next-state choice; DONE is left only through the power-on reset.
    always_comb begin
        state_nx = state_q;
        case (state_q)
            ST_IDLE: state_nx = ST_COPY;
            ST_COPY: if (last_wr_i) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_DONE;
            default: state_nx = ST_IDLE;
        endcase
        done_next_o = (state_nx == ST_DONE);
    end

    // State register and byte request counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (rd_en_o) cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/boot_word_packer.sv
// Byte-to-word packer.
// Delays the read strobe and address by the one-cycle ROM latency, so each
// returning byte is matched with its own address. Lower lanes are held until
// the top lane arrives, and then the full word is written with a registered
// strobe. Lane 0 (lowest byte address) lands in the least significant bits.
// Assumes: WORD_BITS/BYTE_BITS is a power of two, at least 2;
// RAM_AW can address ROM_BYTES/lanes words.
module boot_word_packer #(
    parameter int BYTE_BITS = 8,
    parameter int WORD_BITS = 16,
    parameter int ROM_BYTES = 128,
    parameter int RAM_AW    = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en_i,
    input  logic [$clog2(ROM_BYTES)-1:0] rd_addr_i,
    input  logic [BYTE_BITS-1:0]         rom_data_i,
    output logic                         ram_we_o,
    output logic [RAM_AW-1:0]            ram_addr_o,
    output logic [WORD_BITS-1:0]         ram_wdata_o,
    output logic                         last_wr_o
);
    localparam int BA    = $clog2(ROM_BYTES);
    localparam int LANES = WORD_BITS / BYTE_BITS;
    localparam int LW    = $clog2(LANES);
    localparam int WORDS = ROM_BYTES / LANES;

    logic                 vld_q;
    logic [BA-1:0]        addr_q;
    logic [BYTE_BITS-1:0] hold_q [LANES-1];
    logic [WORD_BITS-1:0] word_c;
    logic [LW-1:0]        lane_c;
    logic [BA-LW-1:0]     widx_c;

    // Split the delayed byte address into lane and word index.
    always_comb begin
        lane_c = addr_q[LW-1:0];
        widx_c = addr_q[BA-1:LW];
    end

    // Align the strobe and the address with the returning ROM data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            vld_q  <= rd_en_i;
            addr_q <= rd_addr_i;
        end
    end

    // One holding register per lower lane, with the top lane taken live.
    for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) hold_q[g] <= '0;
            else if (vld_q && (lane_c == LW'(g))) hold_q[g] <= rom_data_i;
        end
        assign word_c[g*BYTE_BITS +: BYTE_BITS] = hold_q[g];
    end
    assign word_c[WORD_BITS-1 -: BYTE_BITS] = rom_data_i;

    // Registered RAM write once the top lane of a word has arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we_o    <= 1'b0;
            ram_addr_o  <= '0;
            ram_wdata_o <= '0;
        end else begin
            ram_we_o <= vld_q && (lane_c == LW'(LANES - 1));
            if (vld_q && (lane_c == LW'(LANES - 1))) begin
                ram_addr_o  <= RAM_AW'(widx_c);
                ram_wdata_o <= word_c;
            end
        end
    end

    // Flags the write of the final image word.
    assign last_wr_o = ram_we_o && (ram_addr_o == RAM_AW'(WORDS - 1));

endmodule

// File: rtl/boot_core_rst_gate.sv
// Core reset gate.
// Holds the core in reset until the preload completes, and afterwards follows
// the warm reset request with one register stage.
// Assumes: done_next_i is the sequencer's next-state DONE indication.
module boot_core_rst_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic warm_rst_n,
    input  logic done_next_i,
    output logic core_rst_n_o,
    output logic boot_done_o
);
    // Done flag and registered core reset, both cleared by power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_done_o  <= 1'b0;
            core_rst_n_o <= 1'b0;
        end else begin
            boot_done_o  <= done_next_i;
            core_rst_n_o <= done_next_i && warm_rst_n;
        end
    end

endmodule

// File: rtl/boot_preload.sv
// Boot image preloader, top level.
// After each power-on reset, copies the ROM image into the bottom of the
// instruction RAM, then releases the core reset. A warm reset re-resets the
// core without repeating the copy.
// Assumes: the ROM is read-only with one cycle of read latency; the RAM accepts
// one word per cycle with no back-pressure.
module boot_preload #(
    parameter int ROM_BYTES = 128,
    parameter int BYTE_BITS = 8,
    parameter int WORD_BITS = 16,
    parameter int RAM_WORDS = 512,
    localparam int ROM_AW   = $clog2(ROM_BYTES),
    localparam int RAM_AW   = $clog2(RAM_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 warm_rst_n,
    output logic                 rom_rd_en,
    output logic [ROM_AW-1:0]    rom_addr,
    input  logic [BYTE_BITS-1:0] rom_data,
    output logic                 ram_we,
    output logic [RAM_AW-1:0]    ram_addr,
    output logic [WORD_BITS-1:0] ram_wdata,
    output logic                 core_rst_n,
    output logic                 boot_done
);
    logic last_wr;
    logic done_next;

    boot_seq_fsm #(
        .ROM_BYTES (ROM_BYTES)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .last_wr_i   (last_wr),
        .rd_en_o     (rom_rd_en),
        .rd_addr_o   (rom_addr),
        .done_next_o (done_next)
    );

    boot_word_packer #(
        .BYTE_BITS (BYTE_BITS),
        .WORD_BITS (WORD_BITS),
        .ROM_BYTES (ROM_BYTES),
        .RAM_AW    (RAM_AW)
    ) i_packer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en_i     (rom_rd_en),
        .rd_addr_i   (rom_addr),
        .rom_data_i  (rom_data),
        .ram_we_o    (ram_we),
        .ram_addr_o  (ram_addr),
        .ram_wdata_o (ram_wdata),
        .last_wr_o   (last_wr)
    );

    boot_core_rst_gate i_rst_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .warm_rst_n   (warm_rst_n),
        .done_next_i  (done_next),
        .core_rst_n_o (core_rst_n),
        .boot_done_o  (boot_done)
    );

endmodule

// File: rtl/boot_preload_chk.sv
// Protocol checker for boot_preload, attached by bind.
// Assumes: the same parameters as the bound instance.
module boot_preload_chk #(
    parameter int ROM_BYTES = 128,
    parameter int WORD_BITS = 16,
    parameter int BYTE_BITS = 8,
    parameter int RAM_WORDS = 512,
    localparam int ROM_AW   = $clog2(ROM_BYTES),
    localparam int RAM_AW   = $clog2(RAM_WORDS),
    localparam int WORDS    = ROM_BYTES / (WORD_BITS / BYTE_BITS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              warm_rst_n,
    input logic              rom_rd_en,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              core_rst_n,
    input logic              boot_done
);
    // R1: one edge into power-on reset, every control output is quiet.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!core_rst_n && !boot_done && !ram_we && !rom_rd_en));

    // R2: back-to-back reads step through the byte addresses by one.
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd_en && $past(rom_rd_en)) |-> (rom_addr == ROM_AW'($past(rom_addr) + 1'b1)));

    // R4: writes stay inside the image window.
    assert_low_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr < RAM_AW'(WORDS)));

    // R5: the core is never released before the preload completes.
    assert_rst_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done |-> !core_rst_n);

    // R5: completion follows the write of the final word.
    assert_release_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_done) |-> ($past(ram_we) && ($past(ram_addr) == RAM_AW'(WORDS - 1))));

    // R6: completion is sticky and silences both memory ports.
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);
    assert_no_late_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |-> (!ram_we && !rom_rd_en));

    // R7: a warm reset request puts the core back into reset on the next cycle.
    assert_warm_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_rst_n |=> !core_rst_n);

endmodule

bind boot_preload boot_preload_chk #(
    .ROM_BYTES (ROM_BYTES),
    .WORD_BITS (WORD_BITS),
    .BYTE_BITS (BYTE_BITS),
    .RAM_WORDS (RAM_WORDS)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_rst_n (warm_rst_n),
    .rom_rd_en  (rom_rd_en),
    .rom_addr   (rom_addr),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .core_rst_n (core_rst_n),
    .boot_done  (boot_done)
);

// File: tb/test_boot_preload.sv
`timescale 1ns/1ps
module test_boot_preload;
    localparam int ROM_BYTES = 128;
    localparam int RAM_WORDS = 512;
    localparam int WORDS     = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic        rom_rd_en;
    logic [6:0]  rom_addr;
    logic [7:0]  rom_data;
    logic        ram_we;
    logic [8:0]  ram_addr;
    logic [15:0] ram_wdata;
    logic        core_rst_n;
    logic        boot_done;

    int n_tests = 0;
    int n_fail  = 0;
    int seed    = 1;
    int cycles  = 0;

    logic        ram_fill = 1'b0;
    logic        mon_clr  = 1'b0;
    logic [15:0] ram [RAM_WORDS];
    int rd_cnt, rd_bad, wr_cnt, wr_bad, wd_bad;

    always #2.5 clk = ~clk;

    boot_preload i_boot_preload (
        .clk (clk), .rst_n (rst_n), .warm_rst_n (warm_rst_n),
        .rom_rd_en (rom_rd_en), .rom_addr (rom_addr), .rom_data (rom_data),
        .ram_we (ram_we), .ram_addr (ram_addr), .ram_wdata (ram_wdata),
        .core_rst_n (core_rst_n), .boot_done (boot_done)
    );

    function automatic logic [7:0] rom_byte(int a, int s);
        return 8'((a * 29 + s * 71 + 90) ^ (a >> 1));
    endfunction

    function automatic logic [15:0] exp_word(int n, int s);
        return {rom_byte(2 * n + 1, s), rom_byte(2 * n, s)};
    endfunction

    function automatic logic [15:0] fill_val(int i);
        return 16'hA000 ^ 16'(i);
    endfunction

    // ROM model with one cycle of read latency
    always @(posedge clk) if (rom_rd_en) rom_data <= rom_byte(int'(rom_addr), seed);

    // RAM model plus traffic monitor
    always @(posedge clk) begin
        if (ram_fill) begin
            for (int i = 0; i < RAM_WORDS; i++) ram[i] <= fill_val(i);
        end else if (ram_we) begin
            ram[ram_addr] <= ram_wdata;
        end
        if (mon_clr) begin
            rd_cnt = 0; rd_bad = 0; wr_cnt = 0; wr_bad = 0; wd_bad = 0;
        end else begin
            if (rom_rd_en) begin
                if (int'(rom_addr) != rd_cnt) rd_bad++;
                rd_cnt++;
            end
            if (ram_we) begin
                if (int'(ram_addr) != wr_cnt) wr_bad++;
                if (ram_wdata != exp_word(int'(ram_addr), seed)) wd_bad++;
                wr_cnt++;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Power-on reset and copy; optional warm pulse mid-copy (R8)
    task automatic power_on(input int s, input bit warm_pulse);
        bit early_release = 0;
        @(negedge clk);
        rst_n = 1'b0; seed = s; ram_fill = 1'b1; mon_clr = 1'b1;
        @(negedge clk);
        ram_fill = 1'b0;
        repeat (3) @(negedge clk);
        check(!core_rst_n && !boot_done && !ram_we && !rom_rd_en, "R1 reset state",
              {core_rst_n, boot_done, ram_we, rom_rd_en}, 0);
        mon_clr = 1'b0;
        rst_n = 1'b1;
        for (int e = 1; e <= 131; e++) begin
            @(posedge clk); @(negedge clk);
            if (warm_pulse && e == 40) warm_rst_n = 1'b0;
            if (warm_pulse && e == 60) warm_rst_n = 1'b1;
            if (e < 131 && (core_rst_n || boot_done)) early_release = 1;
        end
        check(!early_release, warm_pulse ? "R8 no early release" : "R5 no early release",
              early_release, 0);
        check(core_rst_n && boot_done, warm_pulse ? "R8 release on edge 131" : "R5 release on edge 131",
              {core_rst_n, boot_done}, 2'b11);
    endtask

    task automatic check_image(input string tag);
        int bad_lo = 0, bad_hi = 0;
        check(rd_cnt == ROM_BYTES && rd_bad == 0, {tag, " R2 read sequence"}, rd_cnt + (rd_bad << 16), ROM_BYTES);
        check(wr_cnt == WORDS && wr_bad == 0, {tag, " R4 write sequence"}, wr_cnt + (wr_bad << 16), WORDS);
        check(wd_bad == 0, {tag, " R3 write data lanes"}, wd_bad, 0);
        for (int i = 0; i < WORDS; i++) if (ram[i] != exp_word(i, seed)) bad_lo++;
        check(bad_lo == 0, {tag, " R3 RAM image words"}, bad_lo, 0);
        for (int i = WORDS; i < RAM_WORDS; i++) if (ram[i] != fill_val(i)) bad_hi++;
        check(bad_hi == 0, {tag, " R4 RAM above image untouched"}, bad_hi, 0);
    endtask

    task automatic test_first_boot();
        power_on(1, 1'b0);
        check_image("boot1");
        check(ram[0] == {rom_byte(1, 1), rom_byte(0, 1)}, "R3 low byte first in word 0",
              ram[0], {rom_byte(1, 1), rom_byte(0, 1)});
    endtask

    task automatic test_hold_after_done();
        repeat (25) @(negedge clk);
        check(boot_done && core_rst_n, "R6 done held", {boot_done, core_rst_n}, 2'b11);
        check(rd_cnt == ROM_BYTES && wr_cnt == WORDS, "R6 no access after done",
              rd_cnt + (wr_cnt << 16), ROM_BYTES + (WORDS << 16));
    endtask

    task automatic test_warm_reset();
        @(negedge clk); warm_rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(!core_rst_n && boot_done, "R7 warm reset asserts core reset", {core_rst_n, boot_done}, 2'b01);
        repeat (4) @(negedge clk);
        check(!core_rst_n, "R7 core reset held while warm low", core_rst_n, 0);
        warm_rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(core_rst_n && boot_done, "R7 core released after warm", {core_rst_n, boot_done}, 2'b11);
        repeat (10) @(negedge clk);
        check(rd_cnt == ROM_BYTES && wr_cnt == WORDS, "R7 no copy repeated",
              rd_cnt + (wr_cnt << 16), ROM_BYTES + (WORDS << 16));
    endtask

    task automatic test_warm_during_copy();
        power_on(5, 1'b1);
        check_image("warmcopy R8");
    endtask

    task automatic test_repower();
        power_on(9, 1'b0);
        check_image("repower R9");
        check(ram[3] == exp_word(3, 9) && ram[3] != exp_word(3, 5), "R9 previous image overwritten",
              ram[3], exp_word(3, 9));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_first_boot();
        test_hold_after_done();
        test_warm_reset();
        test_warm_during_copy();
        test_repower();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule